// File: doc/BRIEF.md
# Graphics Command Packet Framer

The framer accepts a stream of 32-bit command words and cuts it into whole packets for a rendering back end. The top byte of the first word of each packet is the opcode. For fixed-size drawing commands, the opcode sets how many parameter words follow. Two families of line-strip commands have no fixed size: each ends at the first word, from a given position on, that matches a masked terminator pattern.

Three kinds of command are consumed inside the block and never reach the packet output:
- Image-transfer commands produce a one-cycle start pulse for a separate transfer engine.
- Settings commands write a bank of eight 32-bit settings registers.
- The parameters of textured drawing commands also patch one field of the settings bank.

When a packet completes, a 13-bit status word is refreshed from two of the settings registers.

Words enter on a valid/ready interface. A packet is held in an internal buffer until its last word has arrived. It then leaves on a valid/ready output with start and end markers. Input is accepted while `in_ready` is high. `in_ready` stays low from the cycle after a forwarded packet's last word is accepted until the handshake of that packet's end word. While `out_valid` is high and `out_ready` is low, the output word and its markers are held unchanged.

Top module: `cmd_packet_framer`

## Requirements
- R1: The opcode is bits 31:24 of a packet's first word. Polygon opcodes are followed by this many extra words: 0x20-0x23 three, 0x24-0x27 six, 0x28-0x2B four, 0x2C-0x2F eight, 0x30-0x33 five, 0x34-0x37 eight, 0x38-0x3B seven, 0x3C-0x3F eleven. Each such command is forwarded as one packet of exactly that many words plus the opcode word.
- R2: Opcode 0x02 is forwarded with two extra words. Any opcode not covered by another requirement is forwarded as a one-word packet.
- R3: A packet with opcode 0x48-0x4F ends at the first word at index 3 or above (opcode word = index 0) whose value ANDed with 0xF000F000 equals 0x50005000. That word is included in the packet. A matching word at index 1 or 2 does not end it.
- R4: A packet with opcode 0x58-0x5F ends only at a matching word at an even index of 4 or above. A matching word at an odd index does not end it.
- R5: A line-strip packet that reaches 256 words without a terminator ends at its 256th word. `strip_overflow` is then high for the one cycle that follows that word's acceptance.
- R6: Opcodes 0xA0-0xDF take two extra words and are not forwarded. In the cycle after the third word is accepted, `xfer_start` is high for one cycle. In that cycle `xfer_read` is 1 exactly when opcode bits 7:5 are 110, `xfer_pos` is word 1 and `xfer_size` is word 2.
- R7: Opcodes 0xE0-0xE7 are one-word commands that are not forwarded. The whole word is stored in settings register n, where n is opcode bits 2:0. Register n occupies bits 32n+31:32n of `settings`.
- R8: For a textured polygon (opcode 0x20-0x3F with bit 2 set), bits 8:0 of settings register 1 take bits 8:0 of packet word 4. If opcode bit 4 is set, word 5 is used instead.
- R9: When any packet completes, `status` bits 10:0 take settings register 1 bits 10:0 and bits 12:11 take settings register 6 bits 1:0, using the register values after that packet's own update.
- R10: After reset, settings register n holds 0xE0+n in bits 31:24 with zeros below, `status` is 0, `in_ready` is 1 and `out_valid` is 0.
- R11: No word of a packet appears on the output before its last word is accepted. Back-pressure follows the rules stated above.
- R12: `out_sop` marks the first word and `out_eop` marks the last word of every forwarded packet. The words appear in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Framer accepts a word this cycle |
| in_data | input | 32 | Command word |
| out_valid | output | 1 | Packet word presented |
| out_ready | input | 1 | Back end takes the presented word |
| out_data | output | 32 | Packet word |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |
| xfer_start | output | 1 | One-cycle image-transfer start |
| xfer_read | output | 1 | Transfer direction is read |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| strip_overflow | output | 1 | Line strip cut at the word limit |
| settings | output | 256 | Eight settings registers, register n in bits 32n+31:32n |
| status | output | 13 | Status bits mirrored from settings |

## Verification
If the word index or the latched opcode is wrong, the packet boundary moves. That shows at once in the position of `out_eop`, and in `in_ready` dropping a cycle early or late, on the very packet that is affected. Every later packet is then misaligned too, so one miscount corrupts the rest of the stream. A wrong settings write or a wrong texture-field patch is visible on `settings` in the cycle after the command's last word. It reaches `status` at the same edge. A bad transfer decode shows up as a missing, doubled or misdirected `xfer_start` one cycle after the third word.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
  localparam int WORD_W   = 32;
  localparam int OP_W     = 8;
  localparam int NUM_SETS = 8;
  localparam int SEL_W    = $clog2(NUM_SETS);
  localparam int STAT_W   = 13;
  localparam int TP_W     = 9;
  localparam int EXTRA_W  = 4;

  typedef enum logic [2:0] {
    PK_PLAIN,
    PK_STRIP_EVERY,
    PK_STRIP_EVEN,
    PK_XFER,
    PK_SETTING
  } pkt_kind_e;

  typedef enum logic {
    ST_GATHER,
    ST_EMIT
  } frm_state_e;
endpackage

// File: rtl/cpf_opcode_decode.sv
module cpf_opcode_decode
  import cpf_pkg::*;
(
  input  logic [OP_W-1:0]    op,
  output pkt_kind_e          kind,
  output logic [EXTRA_W-1:0] extra,
  output logic               textured,
  output logic [2:0]         tpage_idx
);
  logic [EXTRA_W-1:0] verts;
  logic [EXTRA_W-1:0] per_vert;

  always_comb begin
    kind      = PK_PLAIN;
    extra     = '0;
    textured  = 1'b0;
    tpage_idx = 3'd4;
    verts     = op[3] ? EXTRA_W'(4) : EXTRA_W'(3);
    per_vert  = op[2] ? EXTRA_W'(2) : EXTRA_W'(1);
    if (op == 8'h02) begin
      extra = EXTRA_W'(2);
    end else if (op[7:5] == 3'b001) begin
      // polygon: each vertex carries a position, plus a texture word when
      // textured; shaded polygons add a colour for every vertex but the first
      extra     = EXTRA_W'(verts * per_vert) + (op[4] ? verts - EXTRA_W'(1) : '0);
      textured  = op[2];
      tpage_idx = op[4] ? 3'd5 : 3'd4;
    end else if (op[7:3] == 5'b01001) begin
      kind = PK_STRIP_EVERY;
    end else if (op[7:3] == 5'b01011) begin
      kind = PK_STRIP_EVEN;
    end else if (op >= 8'hA0 && op <= 8'hDF) begin
      kind  = PK_XFER;
      extra = EXTRA_W'(2);
    end else if (op[7:3] == 5'b11100) begin
      kind = PK_SETTING;
    end
  end
endmodule

// File: rtl/cpf_collector.sv
module cpf_collector
  import cpf_pkg::*;
#(
  parameter int               MAX_WORDS    = 256,
  parameter logic [WORD_W-1:0] TERM_PATTERN = 32'h5000_5000,
  parameter logic [WORD_W-1:0] TERM_MASK    = 32'hF000_F000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              xfer_start,
  output logic              xfer_read,
  output logic [WORD_W-1:0] xfer_pos,
  output logic [WORD_W-1:0] xfer_size,
  output logic              strip_overflow,
  output logic              set_wr,
  output logic [SEL_W-1:0]  set_sel,
  output logic [WORD_W-1:0] set_data,
  output logic              tp_wr,
  output logic [TP_W-1:0]   tp_bits,
  output logic              pkt_done
);
  localparam int IDX_W = $clog2(MAX_WORDS);
  localparam int CNT_W = IDX_W + 1;

  frm_state_e         state_q;
  logic [IDX_W-1:0]   idx_q;
  logic [IDX_W-1:0]   rd_q;
  logic [CNT_W-1:0]   len_q;
  logic [OP_W-1:0]    op_q;
  logic [WORD_W-1:0]  w1_q;
  logic [TP_W-1:0]    tpage_q;
  logic [WORD_W-1:0]  mem_q [MAX_WORDS];
  logic               xfer_start_q, xfer_read_q, ovf_q;
  logic [WORD_W-1:0]  xfer_pos_q, xfer_size_q;

  logic [OP_W-1:0]    cur_op;
  pkt_kind_e          dec_kind;
  logic [EXTRA_W-1:0] dec_extra;
  logic               dec_tex;
  logic [2:0]         dec_tp_idx;
  logic               in_fire, out_fire, term_hit, done, is_strip, forced;
  logic               pkt_end, fwd, last_out;

  assign cur_op = (idx_q == '0) ? in_data[WORD_W-1 -: OP_W] : op_q;

  cpf_opcode_decode u_dec (
    .op        (cur_op),
    .kind      (dec_kind),
    .extra     (dec_extra),
    .textured  (dec_tex),
    .tpage_idx (dec_tp_idx)
  );

  assign in_ready = (state_q == ST_GATHER);
  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;
  assign term_hit = ((in_data & TERM_MASK) == TERM_PATTERN);
  assign is_strip = (dec_kind == PK_STRIP_EVERY) || (dec_kind == PK_STRIP_EVEN);
  assign fwd      = (dec_kind != PK_XFER) && (dec_kind != PK_SETTING);

  always_comb begin
    unique case (dec_kind)
      PK_STRIP_EVERY: done = (idx_q >= IDX_W'(3)) && term_hit;
      PK_STRIP_EVEN:  done = (idx_q >= IDX_W'(4)) && !idx_q[0] && term_hit;
      PK_SETTING:     done = 1'b1;
      default:        done = (idx_q == IDX_W'(dec_extra));
    endcase
  end

  assign forced  = is_strip && !done && (idx_q == IDX_W'(MAX_WORDS - 1));
  assign pkt_end = in_fire && (done || forced);

  assign set_wr   = pkt_end && (dec_kind == PK_SETTING);
  assign set_sel  = cur_op[SEL_W-1:0];
  assign set_data = in_data;
  assign tp_wr    = pkt_end && dec_tex;
  assign tp_bits  = (idx_q == IDX_W'(dec_tp_idx)) ? in_data[TP_W-1:0] : tpage_q;
  assign pkt_done = pkt_end;

  always_ff @(posedge clk) begin
    if (in_fire) mem_q[idx_q] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_GATHER;
      idx_q        <= '0;
      rd_q         <= '0;
      len_q        <= '0;
      op_q         <= '0;
      w1_q         <= '0;
      tpage_q      <= '0;
      xfer_start_q <= 1'b0;
      xfer_read_q  <= 1'b0;
      xfer_pos_q   <= '0;
      xfer_size_q  <= '0;
      ovf_q        <= 1'b0;
    end else begin
      xfer_start_q <= 1'b0;
      ovf_q        <= 1'b0;
      if (in_fire) begin
        if (idx_q == '0) op_q <= in_data[WORD_W-1 -: OP_W];
        if (idx_q == IDX_W'(1)) w1_q <= in_data;
        if (idx_q == IDX_W'(dec_tp_idx)) tpage_q <= in_data[TP_W-1:0];
        if (pkt_end) begin
          idx_q <= '0;
          ovf_q <= forced;
          if (fwd) begin
            state_q <= ST_EMIT;
            len_q   <= CNT_W'(idx_q) + CNT_W'(1);
            rd_q    <= '0;
          end
          if (dec_kind == PK_XFER) begin
            xfer_start_q <= 1'b1;
            xfer_read_q  <= (cur_op[7:5] == 3'b110);
            xfer_pos_q   <= w1_q;
            xfer_size_q  <= in_data;
          end
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
      if (out_fire) begin
        if (last_out) state_q <= ST_GATHER;
        else          rd_q    <= rd_q + IDX_W'(1);
      end
    end
  end

  assign last_out       = (CNT_W'(rd_q) + CNT_W'(1) == len_q);
  assign out_valid      = (state_q == ST_EMIT);
  assign out_data       = mem_q[rd_q];
  assign out_sop        = (rd_q == '0);
  assign out_eop        = last_out;
  assign xfer_start     = xfer_start_q;
  assign xfer_read      = xfer_read_q;
  assign xfer_pos       = xfer_pos_q;
  assign xfer_size      = xfer_size_q;
  assign strip_overflow = ovf_q;

  // R11: a stalled output word and its markers stay put
  a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_eop) && $stable(out_sop));

  // R5: a cut strip is waiting at the output, first word first
  a_r5_cut_strip_presented: assert property (@(posedge clk) disable iff (!rst_n)
    strip_overflow |-> out_valid && out_sop);

  // R6: a transfer pulse is one cycle and leaves the input open
  a_r6_xfer_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> in_ready ##1 !xfer_start);

  // R12: the end marker closes the packet and reopens the input
  a_r12_eop_reopens: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eop |=> in_ready && !out_valid);
endmodule

// File: rtl/cpf_settings_bank.sv
module cpf_settings_bank
  import cpf_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         set_wr,
  input  logic [SEL_W-1:0]             set_sel,
  input  logic [WORD_W-1:0]            set_data,
  input  logic                         tp_wr,
  input  logic [TP_W-1:0]              tp_bits,
  input  logic                         pkt_done,
  output logic [NUM_SETS*WORD_W-1:0]   settings,
  output logic [STAT_W-1:0]            status
);
  localparam int TP_REG  = 1;
  localparam int MSK_REG = 6;

  logic [WORD_W-1:0] reg_q [NUM_SETS];
  logic [WORD_W-1:0] reg_d [NUM_SETS];
  logic [STAT_W-1:0] status_q;

  for (genvar i = 0; i < NUM_SETS; i++) begin : g_reg
    always_comb begin
      reg_d[i] = reg_q[i];
      if (set_wr && (set_sel == SEL_W'(i))) begin
        reg_d[i] = set_data;
      end else if (tp_wr && (i == TP_REG)) begin
        reg_d[i][TP_W-1:0] = tp_bits;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q[i] <= {8'hE0 + 8'(i), 24'h0};
      else        reg_q[i] <= reg_d[i];
    end

    assign settings[i*WORD_W +: WORD_W] = reg_q[i];

    // R7: every register keeps its own tag in the top byte
    a_r7_tag_kept: assert property (@(posedge clk) disable iff (!rst_n)
      reg_q[i][31:24] == 8'hE0 + 8'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        status_q <= '0;
    else if (pkt_done) status_q <= {reg_d[MSK_REG][1:0], reg_d[TP_REG][10:0]};
  end

  assign status = status_q;

  // R9: after a packet the status mirrors the settings just written
  a_r9_status_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> status == {reg_q[MSK_REG][1:0], reg_q[TP_REG][10:0]});
endmodule

// File: rtl/cmd_packet_framer.sv
module cmd_packet_framer
  import cpf_pkg::*;
#(
  parameter int                MAX_WORDS    = 256,
  parameter logic [WORD_W-1:0] TERM_PATTERN = 32'h5000_5000,
  parameter logic [WORD_W-1:0] TERM_MASK    = 32'hF000_F000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [WORD_W-1:0]          in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [WORD_W-1:0]          out_data,
  output logic                       out_sop,
  output logic                       out_eop,
  output logic                       xfer_start,
  output logic                       xfer_read,
  output logic [WORD_W-1:0]          xfer_pos,
  output logic [WORD_W-1:0]          xfer_size,
  output logic                       strip_overflow,
  output logic [NUM_SETS*WORD_W-1:0] settings,
  output logic [STAT_W-1:0]          status
);
  logic              set_wr, tp_wr, pkt_done;
  logic [SEL_W-1:0]  set_sel;
  logic [WORD_W-1:0] set_data;
  logic [TP_W-1:0]   tp_bits;

  cpf_collector #(
    .MAX_WORDS    (MAX_WORDS),
    .TERM_PATTERN (TERM_PATTERN),
    .TERM_MASK    (TERM_MASK)
  ) u_coll (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .in_data        (in_data),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_data       (out_data),
    .out_sop        (out_sop),
    .out_eop        (out_eop),
    .xfer_start     (xfer_start),
    .xfer_read      (xfer_read),
    .xfer_pos       (xfer_pos),
    .xfer_size      (xfer_size),
    .strip_overflow (strip_overflow),
    .set_wr         (set_wr),
    .set_sel        (set_sel),
    .set_data       (set_data),
    .tp_wr          (tp_wr),
    .tp_bits        (tp_bits),
    .pkt_done       (pkt_done)
  );

  cpf_settings_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_wr   (set_wr),
    .set_sel  (set_sel),
    .set_data (set_data),
    .tp_wr    (tp_wr),
    .tp_bits  (tp_bits),
    .pkt_done (pkt_done),
    .settings (settings),
    .status   (status)
  );
endmodule

// File: tb/cmd_packet_framer_tb_top.sv
module cmd_packet_framer_tb_top;
  localparam logic [31:0] PAT   = 32'h5000_5000;
  localparam logic [31:0] MSK   = 32'hF000_F000;
  localparam int          LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, out_sop, out_eop, xfer_start, xfer_read, strip_overflow;
  logic [31:0] out_data, xfer_pos, xfer_size;
  logic [255:0] settings;
  logic [12:0] status;

  always #4 clk = ~clk;

  cmd_packet_framer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .xfer_start(xfer_start), .xfer_read(xfer_read), .xfer_pos(xfer_pos),
    .xfer_size(xfer_size), .strip_overflow(strip_overflow), .settings(settings), .status(status)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [31:0] stim[$];
  logic [31:0] m_cur[$];
  logic [33:0] m_out[$];
  string       m_tag[$];
  logic [31:0] m_set[8];
  logic [12:0] m_status;
  bit          m_xs, m_xr, m_ovf;
  logic [31:0] m_xpos, m_xsize;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int fixed_extra(input logic [7:0] op);
    case (op) inside
      8'h02:          return 2;
      [8'h20:8'h23]:  return 3;
      [8'h24:8'h27]:  return 6;
      [8'h28:8'h2B]:  return 4;
      [8'h2C:8'h2F]:  return 8;
      [8'h30:8'h33]:  return 5;
      [8'h34:8'h37]:  return 8;
      [8'h38:8'h3B]:  return 7;
      [8'h3C:8'h3F]:  return 11;
      default:        return 0;
    endcase
  endfunction

  task automatic model_in(input logic [31:0] w);
    int n;
    logic [7:0] op;
    bit done, fwd, strip, ovf;
    string tag;
    m_cur.push_back(w);
    n = m_cur.size();
    op = m_cur[0][31:24];
    done = 0; fwd = 1; strip = 0; ovf = 0; tag = "R1";
    if (op inside {[8'h48:8'h4F]}) begin
      strip = 1; tag = "R3";
      done = (n - 1 >= 3) && ((w & MSK) == PAT);
    end else if (op inside {[8'h58:8'h5F]}) begin
      strip = 1; tag = "R4";
      done = (n - 1 >= 4) && ((n - 1) % 2 == 0) && ((w & MSK) == PAT);
    end else if (op inside {[8'hA0:8'hDF]}) begin
      fwd = 0; done = (n == 3);
    end else if (op inside {[8'hE0:8'hE7]}) begin
      fwd = 0; done = 1;
    end else begin
      if (fixed_extra(op) == 0 || op == 8'h02) tag = "R2";
      done = (n == fixed_extra(op) + 1);
    end
    if (strip && !done && n == 256) begin done = 1; ovf = 1; tag = "R5"; end
    if (!done) return;
    if (fwd) begin
      for (int k = 0; k < n; k++) begin
        m_out.push_back({k == 0, k == n - 1, m_cur[k]});
        m_tag.push_back(tag);
      end
    end
    if (op inside {[8'hA0:8'hDF]}) begin
      m_xs = 1; m_xr = (op[7:5] == 3'b110); m_xpos = m_cur[1]; m_xsize = m_cur[2];
    end
    if (op inside {[8'hE0:8'hE7]}) m_set[op[2:0]] = w;
    if (op inside {[8'h20:8'h3F]} && op[2]) begin
      logic [31:0] t;
      t = m_cur[op[4] ? 5 : 4];
      m_set[1] = {m_set[1][31:9], t[8:0]};
    end
    m_status = {m_set[6][1:0], m_set[1][10:0]};
    m_ovf = ovf;
    m_cur.delete();
  endtask

  task automatic compare();
    check(in_ready == (m_out.size() == 0), "R11 in_ready", in_ready, m_out.size() == 0);
    check(out_valid == (m_out.size() != 0), "R11 out_valid", out_valid, m_out.size() != 0);
    if (out_valid && m_out.size() != 0) begin
      check(out_data == m_out[0][31:0], {m_tag[0], " out_data"}, out_data, m_out[0][31:0]);
      check({out_sop, out_eop} == m_out[0][33:32], "R12 sop/eop", {out_sop, out_eop}, m_out[0][33:32]);
    end
    for (int i = 0; i < 8; i++)
      check(settings[i*32 +: 32] == m_set[i], (i == 1) ? "R8 settings1" : "R7 settings",
            settings[i*32 +: 32], m_set[i]);
    check(status == m_status, "R9 status", status, m_status);
    check(xfer_start == m_xs, "R6 xfer_start", xfer_start, m_xs);
    if (m_xs) begin
      check(xfer_read == m_xr, "R6 xfer_read", xfer_read, m_xr);
      check(xfer_pos == m_xpos, "R6 xfer_pos", xfer_pos, m_xpos);
      check(xfer_size == m_xsize, "R6 xfer_size", xfer_size, m_xsize);
    end
    check(strip_overflow == m_ovf, "R5 strip_overflow", strip_overflow, m_ovf);
  endtask

  bit pending = 0;

  task automatic step();
    bit in_fire, out_fire;
    @(negedge clk);
    cyc++;
    compare();
    if (!pending) begin
      if (stim.size() > 0 && $urandom_range(0, 3) != 0) begin
        in_valid = 1'b1; in_data = stim[0];
      end else begin
        in_valid = 1'b0;
      end
    end
    out_ready = (cyc > 300 && cyc < 340) ? 1'b0 : ($urandom_range(0, 4) != 0);
    in_fire  = in_valid && in_ready;
    out_fire = out_valid && out_ready;
    m_xs = 0; m_ovf = 0;
    if (out_fire && m_out.size() != 0) begin void'(m_out.pop_front()); void'(m_tag.pop_front()); end
    if (in_fire) begin void'(stim.pop_front()); model_in(in_data); end
    pending = in_valid && !in_fire;
  endtask

  task automatic push_pkt(input logic [31:0] op_word, input int extra, input logic [31:0] base);
    stim.push_back(op_word);
    for (int k = 1; k <= extra; k++) stim.push_back(base + 32'(k));
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_set[i] = {8'hE0 + 8'(i), 24'h0};
    m_status = '0; m_xs = 0; m_xr = 0; m_ovf = 0; m_xpos = '0; m_xsize = '0;

    stim.push_back(32'h0012_3456);                       // R2 one word
    stim.push_back(32'h8000_0000);                       // R2 unlisted opcode
    push_pkt(32'h02AA_BBCC, 2, 32'h0100_0000);           // R2 fill
    push_pkt(32'h2011_2233, 3, 32'h0200_0000);           // R1
    push_pkt(32'h2800_0000, 4, 32'h0300_0000);           // R1
    push_pkt(32'h3C00_0000, 11, 32'h0400_0000);          // R1 largest
    push_pkt(32'h3000_0000, 5, 32'h0500_0000);           // R1
    push_pkt(32'h3800_0000, 7, 32'h0600_0000);           // R1
    // R8 textured, page word at index 4
    stim.push_back(32'h2400_0000); stim.push_back(32'h1); stim.push_back(32'h2);
    stim.push_back(32'h3); stim.push_back(32'h0000_0123); stim.push_back(32'h5); stim.push_back(32'h6);
    // R8 shaded textured, page word at index 5
    stim.push_back(32'h3400_0000); stim.push_back(32'h1); stim.push_back(32'h2);
    stim.push_back(32'h3); stim.push_back(32'h0000_0FFF); stim.push_back(32'h0000_00AB);
    stim.push_back(32'h6); stim.push_back(32'h7); stim.push_back(32'h8);
    push_pkt(32'h2C00_0000, 8, 32'h0000_0170);           // R8 page word index 4
    // R3 strip: early match at index 2 ignored, end at index 5
    stim.push_back(32'h48FF_0000); stim.push_back(32'h0001_0001); stim.push_back(32'h5555_5555);
    stim.push_back(32'h1234_1234); stim.push_back(32'h0020_0020); stim.push_back(32'h5FFF_5FFF);
    // R3 shortest strip, end at index 3
    stim.push_back(32'h4F00_0000); stim.push_back(32'h1); stim.push_back(32'h2); stim.push_back(32'h5000_5000);
    // R4 strip: match at odd index 5 ignored, end at index 6
    stim.push_back(32'h5800_0000); stim.push_back(32'h1); stim.push_back(32'h2); stim.push_back(32'h3);
    stim.push_back(32'h4); stim.push_back(32'h5000_5000); stim.push_back(32'h5111_5111);
    // R6 transfers
    stim.push_back(32'hA000_0000); stim.push_back(32'h0010_0020); stim.push_back(32'h0004_0008);
    stim.push_back(32'hC000_0000); stim.push_back(32'h0001_0002); stim.push_back(32'h0003_0004);
    stim.push_back(32'hDF00_0000); stim.push_back(32'h0005_0006); stim.push_back(32'h0007_0008);
    // R7 settings
    stim.push_back(32'hE100_05A5); stim.push_back(32'hE600_0003); stim.push_back(32'hE3AB_CDEF);
    stim.push_back(32'hE7FF_FFFF); stim.push_back(32'h0000_0000);
    push_pkt(32'h3C00_0000, 11, 32'h0000_0010);          // R8 after a setting write
    stim.push_back(32'hE600_0001);
    // R5 strip without terminator: cut at 256, rest become one-word packets
    stim.push_back(32'h4A00_0000);
    for (int k = 1; k < 300; k++) stim.push_back(32'h0000_0001);
    push_pkt(32'h5C00_0000, 2, 32'h0);
    stim.push_back(32'h5C5C_5C5C); stim.push_back(32'h5000_5000);   // R4 end at index 4
    push_pkt(32'h2400_0000, 6, 32'h0000_0040);

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    for (int i = 0; i < 8; i++)
      check(settings[i*32 +: 32] == {8'hE0 + 8'(i), 24'h0}, "R10 settings reset",
            settings[i*32 +: 32], {8'hE0 + 8'(i), 24'h0});
    check(status == 13'h0, "R10 status reset", status, 0);
    check(in_ready === 1'b1, "R10 in_ready reset", in_ready, 1);
    check(out_valid === 1'b0, "R10 out_valid reset", out_valid, 0);

    while (stim.size() > 0 || m_cur.size() > 0 || m_out.size() > 0 || pending) begin
      if (cyc > LIMIT) begin
        check(1'b0, "watchdog", cyc, LIMIT);
        break;
      end
      step();
    end
    repeat (4) step();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule